// File: doc/BRIEF.md
# Disk Controller Major-State Sequencer

This block decides which single major state a disk drive controller is in. There are seven states: Idle, Recal, Seek, Clear Head, Write, Inc Head and Read. Every state has its own entry condition. The conditions are built from the current state, the class of the function held in the function register, the cylinder and header compare flags, the normal/format mode input and a set of drive and timing events. When a state is entered, the previously active state is dropped in the same clock. In a transfer, the block forces a brief return to Idle at the end of each sector and on each head-address step. This lets the surrounding logic reload the drive before the next pass through Clear Head.

The controller's tag-cycle logic supplies the restart, initiate and execute pulses. The drive supplies the ready, index and sector events. Downstream logic reads the one-hot state vector directly. It also receives a one-cycle entry pulse for each state, which starts the bus cycle belonging to that state. Everything is synchronous to one clock, and all event inputs are sampled on the rising edge.

Top module: `disk_seq_ctrl`

## Requirements
- R1: `state_q` always has exactly one bit set. The bit positions are: 0 Idle, 1 Recal, 2 Seek, 3 Clear Head, 4 Write, 5 Inc Head, 6 Read. Entering a state clears the bit of the state that was active.
- R2: While `rst` is high at a clock edge, the next state is Idle and `enter_pulse` is zero. A `ctl_clear` pulse also moves the block to Idle on the next edge, whatever the current state is.
- R3: Function codes are: 0 idle, 1 seek and 4 recal (initiate-type); 2 read, 3 write and 7 write check (plain transfers); 5 read all and 6 write all. Idle is entered on any one of the following:
  - `job_done`;
  - `tag_restart` with an initiate-type code;
  - `wc_overflow` together with `sector_end`;
  - `head_inc` with code 5 or 6;
  - `sector_end` with a plain transfer code.
- R4: Recal is entered only from Idle, on `initiate`, when the code is 4. That code is the recal/idle class with bit 2 set. Code 0 with `initiate` leaves the block in Idle.
- R5: Seek is entered in two ways:
  - from Idle on `initiate` when the code is 1;
  - from Clear Head on `tag_restart`, when the code is a transfer (2, 3, 5, 6 or 7) and `cyl_match` is low.
- R6: Read is entered from Clear Head on `tag_restart` when the code is a transfer, `normal_mode` is high and `cyl_match` is high.
- R7: Read is entered from Seek only on a low-to-high change of `unit_ready` that follows a seek request made from Clear Head. This also needs a transfer code and normal mode. A `unit_ready` that simply stays high does not cause the entry.
- R8: Write is entered in any of three cases:
  - (format) code 6, not Idle, `cyl_match`, format mode, `index_sync` high and `sector_pulse`;
  - (all, normal) code 6, normal mode, Read state, `hdr_match` and `sector_pulse`;
  - (data, normal) code 3, normal mode, Read state, `hdr_match` and `clk_dlyd`.
- R9: Inc Head is entered from Write on `sector_pulse` when the code is 6, the mode is format and `index_sync` is low.
- R10: Clear Head is entered in two ways:
  - from Idle on `execute` with a transfer code;
  - in format mode, from Seek on the `unit_ready` rising edge that ends a seek requested from Clear Head.
- R11: When several entry conditions hold in one cycle, the winner is chosen in this order: Idle, Recal, Seek, Read, Write, Inc Head, Clear Head.
- R12: `enter_pulse` equals `state_q` for exactly the first cycle of a newly entered state. It is zero at all other times, including when the winning condition names the state that is already active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| ctl_clear | input | 1 | Controller clear pulse |
| fn_code | input | 3 | Function register code |
| cyl_match | input | 1 | Cylinder address equals drive cylinder |
| hdr_match | input | 1 | Header read from disk matches target |
| normal_mode | input | 1 | High for normal, low for format |
| unit_ready | input | 1 | Selected drive ready level |
| clk_dlyd | input | 1 | Delayed data-clock timing pulse |
| sector_end | input | 1 | End of a transferred sector |
| index_sync | input | 1 | Index recently seen |
| sector_pulse | input | 1 | Drive sector pulse |
| wc_overflow | input | 1 | Word count exhausted |
| job_done | input | 1 | Transfer complete or aborted |
| head_inc | input | 1 | Head address has stepped |
| tag_restart | input | 1 | Tag/bus cycle finished |
| initiate | input | 1 | Initiate-type command pulse |
| execute | input | 1 | Transfer command pulse |
| state_q | output | 7 | One-hot major state |
| enter_pulse | output | 7 | One-cycle entry strobe per state |

## Verification
The state flow is driven through the following sequences:
- recal and seek initiate cycles;
- a read that goes directly from Clear Head;
- a read that has to seek first;
- a data write and an all-sectors write in normal mode;
- a format pass that cycles Write and Inc Head and ends with a seek back to Clear Head.

Each sequence separates one entry path from its neighbours. For example, the read after a seek checks that a held-high ready level is not mistaken for a rising edge. The format pass checks that the format write condition differs from the Inc Head condition only in the index level. Simultaneous events check the priority order and confirm that re-selecting the current state produces no strobe. On every clock, a behavioural model compares the expected state and strobe with the outputs.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;

    localparam int NS   = 7;
    localparam int FN_W = 3;

    localparam int ST_IDLE  = 0;
    localparam int ST_RECAL = 1;
    localparam int ST_SEEK  = 2;
    localparam int ST_CLRHD = 3;
    localparam int ST_WRITE = 4;
    localparam int ST_INCHD = 5;
    localparam int ST_READ  = 6;

    typedef logic [NS-1:0]   st_vec_t;
    typedef logic [FN_W-1:0] fn_t;

    localparam fn_t FN_IDLE   = 3'd0;
    localparam fn_t FN_SEEK   = 3'd1;
    localparam fn_t FN_READ   = 3'd2;
    localparam fn_t FN_WRITE  = 3'd3;
    localparam fn_t FN_RECAL  = 3'd4;
    localparam fn_t FN_RDALL  = 3'd5;
    localparam fn_t FN_WRALL  = 3'd6;
    localparam fn_t FN_WRCHK  = 3'd7;

    typedef struct packed {
        logic init_type;   // idle, seek, recal
        logic recal_go;    // recal/idle class with bit 2 set
        logic seek_fn;
        logic xfer;        // any transfer function
        logic plain_xfer;  // read, write, write check
        logic all_fn;      // read all, write all
        logic write_all;
        logic write_data;
    } fn_class_t;

    function automatic fn_class_t classify_fn(fn_t code);
        fn_class_t c;
        c.recal_go   = (code[1:0] == 2'b00) && code[2];
        c.init_type  = (code == FN_IDLE) || (code == FN_SEEK) || (code == FN_RECAL);
        c.seek_fn    = (code == FN_SEEK);
        c.plain_xfer = (code == FN_READ) || (code == FN_WRITE) || (code == FN_WRCHK);
        c.all_fn     = (code == FN_RDALL) || (code == FN_WRALL);
        c.xfer       = c.plain_xfer || c.all_fn;
        c.write_all  = (code == FN_WRALL);
        c.write_data = (code == FN_WRITE);
        return c;
    endfunction

    // rank 0 wins; maps a rank to the state bit it arbitrates for
    function automatic int rank_state(int rank);
        case (rank)
            0:       return ST_IDLE;
            1:       return ST_RECAL;
            2:       return ST_SEEK;
            3:       return ST_READ;
            4:       return ST_WRITE;
            5:       return ST_INCHD;
            default: return ST_CLRHD;
        endcase
    endfunction

endpackage

// File: rtl/disk_seq_ready_track.sv
module disk_seq_ready_track (
    input  logic clk,
    input  logic rst,
    input  logic unit_ready,
    input  logic seek_req,
    output logic ready_rise,
    output logic armed_q
);
    logic ready_d;

    assign ready_rise = unit_ready && !ready_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_d <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ready_d <= unit_ready;
            if (seek_req)
                armed_q <= 1'b1;
            else if (ready_rise)
                armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/disk_seq_set_logic.sv
module disk_seq_set_logic
    import disk_seq_pkg::*;
(
    input  st_vec_t   st,
    input  fn_class_t fc,
    input  logic      ctl_clear,
    input  logic      cyl_match,
    input  logic      hdr_match,
    input  logic      normal_mode,
    input  logic      clk_dlyd,
    input  logic      sector_end,
    input  logic      index_sync,
    input  logic      sector_pulse,
    input  logic      wc_overflow,
    input  logic      job_done,
    input  logic      head_inc,
    input  logic      tag_restart,
    input  logic      initiate,
    input  logic      execute,
    input  logic      ready_rise,
    input  logic      armed_q,
    output logic      seek_req,
    output st_vec_t   set_vec
);
    logic seek_done, wr_fmt, wr_all_norm, wr_data_norm;

    always_comb begin
        seek_req  = st[ST_CLRHD] && tag_restart && fc.xfer && !cyl_match;
        seek_done = st[ST_SEEK] && armed_q && ready_rise && fc.xfer;

        wr_fmt       = !st[ST_IDLE] && fc.write_all && cyl_match && !normal_mode
                       && index_sync && sector_pulse;
        wr_all_norm  = normal_mode && fc.write_all && st[ST_READ] && hdr_match && sector_pulse;
        wr_data_norm = normal_mode && fc.write_data && st[ST_READ] && hdr_match && clk_dlyd;

        set_vec = '0;
        set_vec[ST_IDLE]  = ctl_clear || job_done
                            || (tag_restart && fc.init_type)
                            || (wc_overflow && sector_end)
                            || (head_inc && fc.all_fn)
                            || (sector_end && fc.plain_xfer);
        set_vec[ST_RECAL] = fc.recal_go && st[ST_IDLE] && initiate;
        set_vec[ST_SEEK]  = (fc.seek_fn && st[ST_IDLE] && initiate) || seek_req;
        set_vec[ST_READ]  = normal_mode &&
                            ((st[ST_CLRHD] && tag_restart && fc.xfer && cyl_match) || seek_done);
        set_vec[ST_WRITE] = wr_fmt || wr_all_norm || wr_data_norm;
        set_vec[ST_INCHD] = st[ST_WRITE] && !index_sync && fc.write_all && !normal_mode
                            && sector_pulse;
        set_vec[ST_CLRHD] = (st[ST_IDLE] && execute && fc.xfer) || (seek_done && !normal_mode);
    end
endmodule

// File: rtl/disk_seq_prio_pick.sv
module disk_seq_prio_pick
    import disk_seq_pkg::*;
(
    input  st_vec_t set_vec,
    output st_vec_t grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int k = 0; k < NS; k++) begin
            if (set_vec[rank_state(k)] && !taken) begin
                grant[rank_state(k)] = 1'b1;
                taken = 1'b1;
            end
        end
    end
endmodule

// File: rtl/disk_seq_ctrl.sv
module disk_seq_ctrl
    import disk_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_clear,
    input  logic [FN_W-1:0] fn_code,
    input  logic            cyl_match,
    input  logic            hdr_match,
    input  logic            normal_mode,
    input  logic            unit_ready,
    input  logic            clk_dlyd,
    input  logic            sector_end,
    input  logic            index_sync,
    input  logic            sector_pulse,
    input  logic            wc_overflow,
    input  logic            job_done,
    input  logic            head_inc,
    input  logic            tag_restart,
    input  logic            initiate,
    input  logic            execute,
    output logic [NS-1:0]   state_q,
    output logic [NS-1:0]   enter_pulse
);
    fn_class_t fc;
    st_vec_t   set_vec, grant;
    logic      seek_req, ready_rise, armed_q;

    assign fc = classify_fn(fn_code);

    disk_seq_ready_track u_ready (
        .clk        (clk),
        .rst        (rst),
        .unit_ready (unit_ready),
        .seek_req   (seek_req),
        .ready_rise (ready_rise),
        .armed_q    (armed_q)
    );

    disk_seq_set_logic u_set (
        .st           (state_q),
        .fc           (fc),
        .ctl_clear    (ctl_clear),
        .cyl_match    (cyl_match),
        .hdr_match    (hdr_match),
        .normal_mode  (normal_mode),
        .clk_dlyd     (clk_dlyd),
        .sector_end   (sector_end),
        .index_sync   (index_sync),
        .sector_pulse (sector_pulse),
        .wc_overflow  (wc_overflow),
        .job_done     (job_done),
        .head_inc     (head_inc),
        .tag_restart  (tag_restart),
        .initiate     (initiate),
        .execute      (execute),
        .ready_rise   (ready_rise),
        .armed_q      (armed_q),
        .seek_req     (seek_req),
        .set_vec      (set_vec)
    );

    disk_seq_prio_pick u_pick (
        .set_vec (set_vec),
        .grant   (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= st_vec_t'(1) << ST_IDLE;
            enter_pulse <= '0;
        end else begin
            if (|grant)
                state_q <= grant;
            enter_pulse <= grant & ~state_q;
        end
    end

    assert_one_state_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(state_q) == 1);

    assert_clear_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_clear |=> state_q[ST_IDLE]);

    assert_recal_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q[ST_RECAL]) |-> $past(state_q[ST_IDLE]) && $past(initiate));

    assert_read_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q[ST_READ]) |-> $past(state_q[ST_CLRHD]) || $past(state_q[ST_SEEK]));

    assert_seek_read_edge_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(state_q[ST_READ]) && $past(state_q[ST_SEEK]))
            |-> $past(unit_ready) && !$past(unit_ready, 2));

    assert_write_trigger_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q[ST_WRITE]) |-> $past(sector_pulse) || $past(clk_dlyd));

    assert_inc_from_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q[ST_INCHD]) |-> $past(state_q[ST_WRITE]) && $past(sector_pulse));

    assert_pulse_marks_entry_R12: assert property (@(posedge clk) disable iff (rst)
        (|enter_pulse) |-> (enter_pulse == state_q) && $changed(state_q));

endmodule

// File: tb/disk_seq_ctrl_test.sv
`timescale 1ns/1ps
module disk_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_clear = 0, cyl_match = 0, hdr_match = 0, normal_mode = 0, unit_ready = 0;
    logic clk_dlyd = 0, sector_end = 0, index_sync = 0, sector_pulse = 0, wc_overflow = 0;
    logic job_done = 0, head_inc = 0, tag_restart = 0, initiate = 0, execute = 0;
    logic [2:0] fn_code = 3'd0;
    logic [6:0] state_q, enter_pulse;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    disk_seq_ctrl uut (
        .clk(clk), .rst(rst), .ctl_clear(ctl_clear), .fn_code(fn_code),
        .cyl_match(cyl_match), .hdr_match(hdr_match), .normal_mode(normal_mode),
        .unit_ready(unit_ready), .clk_dlyd(clk_dlyd), .sector_end(sector_end),
        .index_sync(index_sync), .sector_pulse(sector_pulse), .wc_overflow(wc_overflow),
        .job_done(job_done), .head_inc(head_inc), .tag_restart(tag_restart),
        .initiate(initiate), .execute(execute), .state_q(state_q), .enter_pulse(enter_pulse)
    );

    localparam logic [6:0] S_IDLE = 7'h01, S_RECAL = 7'h02, S_SEEK = 7'h04, S_CLRHD = 7'h08,
                           S_WRITE = 7'h10, S_INCHD = 7'h20, S_READ = 7'h40;

    // behavioural reference: state index 0..6, with priority resolved by if-order
    int m_st = 0, m_armed = 0, m_prev = 0;
    logic [6:0] m_pulse = '0;

    always @(posedge clk) begin
        int nxt, f;
        bit initf, plain, allf, xfer, rise, sreq, wr;
        if (rst) begin
            m_st = 0; m_armed = 0; m_prev = 0; m_pulse = '0;
        end else begin
            f     = int'(fn_code);
            initf = (f == 0) || (f == 1) || (f == 4);
            plain = (f == 2) || (f == 3) || (f == 7);
            allf  = (f == 5) || (f == 6);
            xfer  = plain || allf;
            rise  = unit_ready && (m_prev == 0);
            sreq  = (m_st == 3) && tag_restart && xfer && !cyl_match;
            wr = ((m_st != 0) && cyl_match && !normal_mode && index_sync && sector_pulse && f == 6)
              || (normal_mode && f == 6 && m_st == 6 && hdr_match && sector_pulse)
              || (normal_mode && f == 3 && m_st == 6 && hdr_match && clk_dlyd);
            nxt = m_st;
            if (ctl_clear || job_done || (tag_restart && initf) || (wc_overflow && sector_end)
                || (head_inc && allf) || (sector_end && plain))
                nxt = 0;
            else if (f == 4 && m_st == 0 && initiate)
                nxt = 1;
            else if ((f == 1 && m_st == 0 && initiate) || sreq)
                nxt = 2;
            else if (normal_mode && xfer &&
                     ((m_st == 3 && tag_restart && cyl_match) || (m_st == 2 && m_armed != 0 && rise)))
                nxt = 6;
            else if (wr)
                nxt = 4;
            else if (m_st == 4 && !index_sync && f == 6 && !normal_mode && sector_pulse)
                nxt = 5;
            else if ((m_st == 0 && execute && xfer) ||
                     (m_st == 2 && m_armed != 0 && rise && !normal_mode && xfer))
                nxt = 3;
            m_pulse = (nxt != m_st) ? 7'(1 << nxt) : 7'd0;
            m_st = nxt;
            if (sreq) m_armed = 1;
            else if (rise) m_armed = 0;
            m_prev = unit_ready ? 1 : 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (state_q !== 7'(1 << m_st) || enter_pulse !== m_pulse) begin
                n_fail++;
                $display("FAIL R1/R12 model: state=%b pulse=%b expected state=%b pulse=%b",
                         state_q, enter_pulse, 7'(1 << m_st), m_pulse);
            end
        end
    end

    task automatic chk(string req, logic [6:0] exp_st, logic [6:0] exp_pl);
        n_checks++;
        if (state_q !== exp_st || enter_pulse !== exp_pl) begin
            n_fail++;
            $display("FAIL %s: state=%b pulse=%b expected state=%b pulse=%b",
                     req, state_q, enter_pulse, exp_st, exp_pl);
        end
    endtask

    task automatic clear_events();
        ctl_clear = 0; clk_dlyd = 0; sector_end = 0; sector_pulse = 0; wc_overflow = 0;
        job_done = 0; head_inc = 0; tag_restart = 0; initiate = 0; execute = 0;
    endtask

    task automatic fire();
        @(negedge clk);
        clear_events();
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(3);
        chk("R2 reset", S_IDLE, 7'h00);
        rst = 0;
        wait_cyc(2);
        chk("R2 after reset", S_IDLE, 7'h00);

        // R4: recal code with initiate; code 0 does not recal
        fn_code = 3'd0; initiate = 1; fire();
        chk("R4 code0 no recal", S_IDLE, 7'h00);
        fn_code = 3'd4; initiate = 1; fire();
        chk("R4 recal entry", S_RECAL, S_RECAL);
        wait_cyc(1);
        chk("R12 single cycle strobe", S_RECAL, 7'h00);
        tag_restart = 1; fire();
        chk("R3 initiate restart idle", S_IDLE, S_IDLE);

        // R5: seek function
        fn_code = 3'd1; initiate = 1; fire();
        chk("R5 seek fn", S_SEEK, S_SEEK);
        tag_restart = 1; fire();
        chk("R3 seek restart idle", S_IDLE, S_IDLE);

        // R10, R6: direct read, end on sector
        fn_code = 3'd2; normal_mode = 1; cyl_match = 1;
        execute = 1; fire();
        chk("R10 execute clear head", S_CLRHD, S_CLRHD);
        tag_restart = 1; fire();
        chk("R6 direct read", S_READ, S_READ);
        sector_end = 1; fire();
        chk("R3 sector end plain", S_IDLE, S_IDLE);

        // R5, R7: read needing a seek, held ready level ignored
        unit_ready = 1; cyl_match = 0;
        execute = 1; fire();
        tag_restart = 1; fire();
        chk("R5 seek on mismatch", S_SEEK, S_SEEK);
        wait_cyc(3);
        chk("R7 level ready ignored", S_SEEK, 7'h00);
        unit_ready = 0; wait_cyc(1);
        unit_ready = 1; wait_cyc(1);
        chk("R7 read on ready rise", S_READ, S_READ);
        cyl_match = 1;

        // R8 data write normal, then R3 overflow
        fn_code = 3'd3; hdr_match = 1;
        job_done = 1; fire();
        chk("R3 job done", S_IDLE, S_IDLE);
        execute = 1; fire();
        tag_restart = 1; fire();
        chk("R6 read for write", S_READ, S_READ);
        clk_dlyd = 1; fire();
        chk("R8 data write", S_WRITE, S_WRITE);
        wc_overflow = 1; sector_end = 1; fire();
        chk("R3 overflow at sector end", S_IDLE, S_IDLE);

        // R11: idle beats write
        execute = 1; fire();
        tag_restart = 1; fire();
        clk_dlyd = 1; sector_end = 1; fire();
        chk("R11 idle over write", S_IDLE, S_IDLE);

        // R8 all-sector write normal
        fn_code = 3'd6;
        execute = 1; fire();
        tag_restart = 1; fire();
        sector_pulse = 1; fire();
        chk("R8 write all normal", S_WRITE, S_WRITE);
        head_inc = 1; fire();
        chk("R3 head step all fn", S_IDLE, S_IDLE);

        // R8 format write not from Idle
        normal_mode = 0; index_sync = 1;
        sector_pulse = 1; fire();
        chk("R8 format not from idle", S_IDLE, 7'h00);
        execute = 1; fire();
        tag_restart = 1; fire();
        chk("R6 no read in format", S_CLRHD, 7'h00);
        sector_pulse = 1; fire();
        chk("R8 format write", S_WRITE, S_WRITE);
        index_sync = 0; sector_pulse = 1; fire();
        chk("R9 inc head", S_INCHD, S_INCHD);
        index_sync = 1; sector_pulse = 1; fire();
        chk("R8 format rewrite", S_WRITE, S_WRITE);
        head_inc = 1; fire();
        chk("R3 end of cylinder", S_IDLE, S_IDLE);

        // R10: format seek returns to clear head
        cyl_match = 0; unit_ready = 0;
        execute = 1; fire();
        tag_restart = 1; fire();
        chk("R5 format seek", S_SEEK, S_SEEK);
        unit_ready = 1; wait_cyc(1);
        chk("R10 seek to clear head", S_CLRHD, S_CLRHD);

        // R2 clear from active state; R11/R12 clear beats recal in Idle
        ctl_clear = 1; fire();
        chk("R2 controller clear", S_IDLE, S_IDLE);
        fn_code = 3'd4; initiate = 1; ctl_clear = 1; fire();
        chk("R11 clear over recal", S_IDLE, 7'h00);
        wait_cyc(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule